// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This unit samples 28 general-purpose input pins and turns selected transitions on them into sticky interrupt requests. Software arms each pin separately for rising transitions, falling transitions or both. A detected transition sets that pin's bit in a status register. The bit stays set until software writes a 1 to that bit position, so reading the status word and writing the same value back acknowledges exactly the events that were read.

The eleven lowest pins each have a dedicated interrupt line. The remaining seventeen pins share one combined line, which a handler can decode by reading the status word. A separate wake-enable mask selects which latched events also raise a wake request toward the power manager. Every pin passes through a two-stage synchroniser, so the pins may be fully asynchronous to the clock. The register port is a single-cycle write strobe with a two-bit word select. Read data is combinational from the selected register.

Top module: `gpio_edge_irq`

## Requirements
- R1: While reset is asserted and after it is released, the rising-enable, falling-enable, wake-enable and status registers read as zero, and every interrupt line and the wake request are low.
- R2: When a pin's rising-enable bit is set and the pin goes from 0 to 1, its status bit reads 1. A pin level applied before clock edge k appears in the status register after edge k+2.
- R3: When a pin's falling-enable bit is set and the pin goes from 1 to 0, its status bit is set with the same latency as in R2.
- R4: When both enable bits of a pin are set, a rising transition and a falling transition each set the pin's status bit.
- R5: A transition on a pin whose two enable bits are both 0 leaves its status bit at 0. Clearing a pin's enable bits does not clear a status bit that is already set.
- R6: Writing the status word clears each bit that is written as 1 and leaves each bit that is written as 0 unchanged.
- R7: If a new event and a write-one-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R8: Interrupt line n (n = 0 to 10) equals status bit n.
- R9: The combined interrupt line is high exactly when at least one status bit from 11 to 27 is set.
- R10: The wake request is high exactly when some status bit is set and the same bit of the wake-enable register is also set.
- R11: Register word select 0 is the rising enable, 1 the falling enable, 2 the status and 3 the wake enable. Read bits 31:28 are always zero, and written enable values read back unchanged in bits 27:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released to the logic through a synchroniser |
| pin_i | input | 28 | Pin levels, asynchronous to clk |
| reg_wr_i | input | 1 | Write strobe for one cycle |
| reg_addr_i | input | 2 | Register word select (0 rise, 1 fall, 2 status, 3 wake) |
| reg_wdata_i | input | 28 | Write data, one bit per pin |
| reg_rdata_o | output | 32 | Read data of the selected register, bits 31:28 zero |
| irq_pin_o | output | 11 | Dedicated interrupt lines for pins 0 to 10 |
| irq_group_o | output | 1 | Combined interrupt line for pins 11 to 27 |
| wake_o | output | 1 | Wake request |

## Verification
The assertions assume that only the status register and the edge detector change the status bits, and that a status write carries its clear mask for exactly one sampled cycle. The check that a full-mask clear silences every output also assumes that no synchronised transition is pending in that cycle. The bench changes pins and register controls shortly after the rising edge, so the synchroniser always captures a settled level. The bench keeps the pins at 0 through reset, so reset release itself produces no transition. In the random phase, the bench drives only legal word selects and full 28-bit data. Events and clears may then coincide freely, which exercises the priority rule of R7.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  // Register word selects; the status word sits at select 2
  typedef enum logic [1:0] {
    SEL_RISE = 2'd0,
    SEL_FALL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_WAKE = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // Shift ones in after asynchronous assertion: release is synchronous
  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 28,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  localparam int LAST = STAGES - 1;

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stage_d[s] = pin_i;
      end else begin : g_next
        assign stage_d[s] = stage_q[s-1];
      end
    end
  endgenerate

  assign prev_d = stage_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
      prev_q <= prev_d;
    end
  end

  // A transition is a difference between two consecutive settled samples
  assign rise_o =  stage_q[LAST] & ~prev_q;
  assign fall_o = ~stage_q[LAST] &  prev_q;

endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
  import gpio_edge_pkg::*;
#(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rise_en_o,
  output logic [W-1:0] fall_en_o,
  output logic [W-1:0] wake_en_o,
  output logic [W-1:0] clr_o
);

  logic [W-1:0] rise_q, fall_q, wake_q;
  logic         rise_we, fall_we, wake_we;

  always_comb begin
    rise_we = wr_i && (sel_i == SEL_RISE);
    fall_we = wr_i && (sel_i == SEL_FALL);
    wake_we = wr_i && (sel_i == SEL_WAKE);
    clr_o   = (wr_i && (sel_i == SEL_STAT)) ? wdata_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rise_q <= '0;
    else if (rise_we) rise_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fall_q <= '0;
    else if (fall_we) fall_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wake_q <= '0;
    else if (wake_we) wake_q <= wdata_i;
  end

  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
  assign wake_en_o = wake_q;

endmodule

// File: rtl/gpio_edge_capture.sv
module gpio_edge_capture #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);

  logic [W-1:0] evt;
  logic [W-1:0] status_q;
  logic [W-1:0] status_d;

  // A new event takes priority over a clear of the same bit
  always_comb begin
    evt      = (rise_i & rise_en_i) | (fall_i & fall_en_i);
    status_d = (status_q & ~clr_i) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;

  // R6: a cleared bit with no competing event is zero afterwards
  p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((status_q & $past(clr_i) & ~$past(evt)) == '0));

  // R7: an event always leaves its bit set, even against a clear
  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status_q & $past(evt)) == $past(evt)));

  // R5: no bit rises without an armed event in the cycle before
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & ~$past(evt)) == '0));

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS    = 28,
  parameter int NUM_DIRECT  = 11,
  parameter int RDATA_W     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic                  reg_wr_i,
  input  logic [1:0]            reg_addr_i,
  input  logic [NUM_PINS-1:0]   reg_wdata_i,
  output logic [RDATA_W-1:0]    reg_rdata_o,
  output logic [NUM_DIRECT-1:0] irq_pin_o,
  output logic                  irq_group_o,
  output logic                  wake_o
);

  localparam int PAD_W = RDATA_W - NUM_PINS;

  logic                rst_n_s;
  reg_sel_e            sel;
  logic [NUM_PINS-1:0] rise_ev, fall_ev;
  logic [NUM_PINS-1:0] rise_en, fall_en, wake_en, clr_mask;
  logic [NUM_PINS-1:0] status;
  logic [NUM_PINS-1:0] rd_pins;
  logic                edge_any;

  assign sel = reg_sel_e'(reg_addr_i);

  gpio_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .pin_i  (pin_i),
    .rise_o (rise_ev),
    .fall_o (fall_ev)
  );

  gpio_edge_regs #(.W(NUM_PINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_i      (reg_wr_i),
    .sel_i     (sel),
    .wdata_i   (reg_wdata_i),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en),
    .wake_en_o (wake_en),
    .clr_o     (clr_mask)
  );

  gpio_edge_capture #(.W(NUM_PINS)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .rise_i    (rise_ev),
    .fall_i    (fall_ev),
    .rise_en_i (rise_en),
    .fall_en_i (fall_en),
    .clr_i     (clr_mask),
    .status_o  (status)
  );

  // Read mux
  always_comb begin
    case (sel)
      SEL_RISE: rd_pins = rise_en;
      SEL_FALL: rd_pins = fall_en;
      SEL_STAT: rd_pins = status;
      SEL_WAKE: rd_pins = wake_en;
      default:  rd_pins = '0;
    endcase
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign reg_rdata_o = {{PAD_W{1'b0}}, rd_pins};
    end else begin : g_nopad
      assign reg_rdata_o = rd_pins[RDATA_W-1:0];
    end
  endgenerate

  // Output grouping: dedicated lines for low pins, OR for the rest
  generate
    for (genvar i = 0; i < NUM_DIRECT; i++) begin : g_direct
      assign irq_pin_o[i] = status[i];
    end
  endgenerate

  assign irq_group_o = |status[NUM_PINS-1:NUM_DIRECT];
  assign wake_o      = |(status & wake_en);
  assign edge_any    = |(rise_ev | fall_ev);

  // R9: clearing every bit with no transition pending silences all requests
  p_clear_all_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_wr_i && (sel == SEL_STAT) && (&reg_wdata_i) && !edge_any)
      |=> ((irq_pin_o == '0) && !irq_group_o && !wake_o));

endmodule

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 28;
  localparam int ND = 11;
  localparam logic [NP-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_i = '0;
  logic          reg_wr_i = 1'b0;
  logic [1:0]    reg_addr_i = 2'd0;
  logic [NP-1:0] reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic [ND-1:0] irq_pin_o;
  logic          irq_group_o;
  logic          wake_o;

  int checks = 0;
  int errors = 0;
  bit compare_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_irq u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_pin_o   (irq_pin_o),
    .irq_group_o (irq_group_o),
    .wake_o      (wake_o)
  );

  // ---------------- behavioural reference ----------------
  logic [NP-1:0] m_hist[$];
  logic [NP-1:0] m_rise, m_fall, m_wake, m_stat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hist = '{'0, '0, '0};
      m_rise = '0; m_fall = '0; m_wake = '0; m_stat = '0;
    end else begin
      logic [NP-1:0] newer, older, ev;
      newer = m_hist[1];
      older = m_hist[2];
      ev = (newer & ~older & m_rise) | (~newer & older & m_fall);
      if (reg_wr_i && reg_addr_i == 2'd2) m_stat = m_stat & ~reg_wdata_i;
      m_stat = m_stat | ev;
      if (reg_wr_i && reg_addr_i == 2'd0) m_rise = reg_wdata_i;
      if (reg_wr_i && reg_addr_i == 2'd1) m_fall = reg_wdata_i;
      if (reg_wr_i && reg_addr_i == 2'd3) m_wake = reg_wdata_i;
      m_hist.push_front(pin_i);
      void'(m_hist.pop_back());
    end
  end

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {4'h0, m_rise};
      2'd1: return {4'h0, m_fall};
      2'd2: return {4'h0, m_stat};
      default: return {4'h0, m_wake};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Every-clock comparison against the reference
  always @(negedge clk) begin
    if (compare_on && !done) begin
      chk("R8 direct lines", {21'd0, irq_pin_o}, {21'd0, m_stat[ND-1:0]});
      chk("R9 group line", {31'd0, irq_group_o}, {31'd0, |m_stat[NP-1:ND]});
      chk("R10 wake", {31'd0, wake_o}, {31'd0, |(m_stat & m_wake)});
      chk("R11 read data", reg_rdata_o, m_read(reg_addr_i));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [1:0] a, input logic [NP-1:0] d);
    @(posedge clk); #1;
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk); #1;
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr_i = a;
    @(negedge clk);
    d = reg_rdata_o;
  endtask

  task automatic setpins(input logic [NP-1:0] v);
    @(posedge clk); #1;
    pin_i = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    // R1: reset state
    idle(3);
    @(negedge clk);
    chk("R1 irq lines in reset", {20'd0, irq_pin_o, irq_group_o}, 32'd0);
    chk("R1 wake in reset", {31'd0, wake_o}, 32'd0);
    #1 rst_n = 1'b1;
    idle(4);
    compare_on = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], r);
      chk("R1 register after reset", r, 32'd0);
    end

    // R2 / R3 setup: rise on bits 0,20; fall on bits 1,12
    wr(2'd0, 28'h010_0001);
    wr(2'd1, 28'h000_1002);
    setpins(28'h010_1003);
    idle(3);
    rd(2'd2, r);
    chk("R2 rising capture", r, 32'h0010_0001);
    chk("R8 line 0 high", {21'd0, irq_pin_o}, 32'h1);
    chk("R9 group from bit 20", {31'd0, irq_group_o}, 32'h1);

    setpins('0);
    idle(3);
    rd(2'd2, r);
    chk("R3 falling capture", r, 32'h0010_1003);

    // R6: write-one-to-clear
    wr(2'd2, 28'h000_0001);
    rd(2'd2, r);
    chk("R6 single bit clear", r, 32'h0010_1002);
    wr(2'd2, '0);
    rd(2'd2, r);
    chk("R6 zero write no effect", r, 32'h0010_1002);
    wr(2'd2, r[NP-1:0]);
    rd(2'd2, r);
    chk("R6 write back clears all", r, 32'h0);
    chk("R9 group low after clear", {31'd0, irq_group_o}, 32'h0);

    // R4: both edges on pin 5
    wr(2'd0, 28'h010_0021);
    wr(2'd1, 28'h000_1022);
    setpins(28'h000_0020);
    idle(3);
    rd(2'd2, r);
    chk("R4 rising with both armed", r, 32'h0000_0020);
    wr(2'd2, ALL);
    setpins('0);
    idle(3);
    rd(2'd2, r);
    chk("R4 falling with both armed", r, 32'h0000_0020);
    wr(2'd2, ALL);

    // R5: unarmed pin 27, and disarming keeps latched bits
    setpins(28'h800_0000);
    idle(3);
    setpins('0);
    idle(3);
    rd(2'd2, r);
    chk("R5 unarmed pin ignored", r, 32'h0);
    setpins(28'h000_0001);
    idle(3);
    wr(2'd0, '0);
    wr(2'd1, '0);
    rd(2'd2, r);
    chk("R5 latched bit survives disarm", r, 32'h0000_0001);
    setpins('0);
    idle(3);
    wr(2'd2, ALL);
    setpins(28'h000_0001);
    idle(3);
    rd(2'd2, r);
    chk("R5 disarmed pin ignored", r, 32'h0);
    setpins('0);
    idle(3);

    // R10: wake request on pin 20
    wr(2'd3, 28'h010_0000);
    wr(2'd0, 28'h010_0000);
    @(negedge clk);
    chk("R10 wake low with no status", {31'd0, wake_o}, 32'h0);
    setpins(28'h010_0000);
    idle(3);
    @(negedge clk);
    chk("R10 wake high", {31'd0, wake_o}, 32'h1);
    wr(2'd3, '0);
    @(negedge clk);
    chk("R10 wake low when unmasked", {31'd0, wake_o}, 32'h0);
    setpins('0);
    idle(3);
    wr(2'd2, ALL);

    // R7: event and clear on bit 3 in the same cycle
    wr(2'd0, 28'h000_0008);
    setpins(28'h000_0008);
    @(posedge clk);
    @(posedge clk); #1;
    reg_wr_i = 1'b1; reg_addr_i = 2'd2; reg_wdata_i = 28'h000_0008;
    @(posedge clk); #1;
    reg_wr_i = 1'b0;
    rd(2'd2, r);
    chk("R7 event wins over clear", r, 32'h0000_0008);
    setpins('0);
    idle(3);
    wr(2'd2, ALL);

    // R11: register map and upper bits
    wr(2'd0, ALL);
    rd(2'd0, r);
    chk("R11 rise readback", r, 32'h0FFF_FFFF);
    wr(2'd3, 28'h000_0001);
    rd(2'd3, r);
    chk("R11 wake readback", r, 32'h0000_0001);
    wr(2'd1, 28'hA5A_5A5A);
    rd(2'd1, r);
    chk("R11 fall readback", r, 32'h0A5A_5A5A);

    // Random phase, compared every clock
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      if (($urandom % 4) == 0) pin_i = pin_i ^ NP'($urandom);
      reg_addr_i = 2'($urandom);
      reg_wdata_i = NP'($urandom);
      reg_wr_i = (($urandom % 6) == 0);
    end
    @(posedge clk); #1;
    reg_wr_i = 1'b0;
    idle(4);
    @(negedge clk);
    finish_run();
  end

endmodule